// File: doc/BRIEF.md
# Dual-Mode Peripheral Port Controller

This block is the register file for two 7-bit bidirectional peripheral ports. A host reads and writes it one byte at a time. Each port has a data register and a direction register. A per-port mode bit chooses who owns the pins. In controller mode, an internal controller drives the pin levels and output enables through a side interface. In direct mode, the host's data and direction registers drive them. The read-back path returns the live pin level on input bits and the stored value on output bits.

A latch-enable bit claims bit 6 of port 1 as a dedicated input. When it is set, that pin is never driven. It passes through a two-flop synchronizer, and a falling edge produces a one-cycle strobe and sets a sticky interrupt flag. The host clears the flag by writing 1 to it.

The host side is a plain register access port with no back-pressure. A write is accepted on every clock where `host_we` is high. `host_rdata` shows the addressed register combinationally in the same cycle. No stream traffic crosses this block, so it has no valid/ready interface.

Top module: `pport_ctrl`

## Requirements
- R1: After reset, both data registers are 0, both direction registers are 0 (all inputs), both mode bits are 0 (controller mode), latch enable is 0 and the interrupt flag is 0.
- R2: With a port's mode bit at 1 (direct mode), `pin_oe` for that port equals its direction register and `pin_o` equals its data register, from the cycle after the write.
- R3: With a port's mode bit at 0, that port's `pin_o` and `pin_oe` follow `ctl_out` and `ctl_oe` combinationally. Host writes to its data and direction registers are stored but do not change the pins.
- R4: A read of data register offset 0 (port 1) or 1 (port 2) returns, for each bit 0..6, the stored data bit where the direction bit is 1 and the live `pin_i` bit where it is 0. Bit 7 reads 0.
- R5: A read of direction register offset 2 (port 1) or 3 (port 2) returns the 7 bits last written, with bit 7 reading 0.
- R6: The mode register at offset 4 takes port 1's mode from write-data bit 0 and port 2's from bit 1. It is write-only and reads as 0, as does the unmapped offset 7.
- R7: The latch enable at offset 5, write-data bit 0, is write-only and reads 0. While it is 1, `pin_oe[6]` is 0 in both modes, and offset 0 bit 6 returns `pin_i[6]` whatever the direction bit is.
- R8: While latch enable is 1, if `pin_i[6]` is first sampled low at clock edge k after being high, `latch_strobe` is high from edge k+1 to edge k+2 for exactly one cycle. No strobe occurs while latch enable is 0.
- R9: The interrupt flag sets at the edge that ends a strobe cycle and stays set until the host writes a byte with bit 0 = 1 to offset 6. A set in the same cycle wins over the clear. Offset 6 reads the flag in bit 0 and 0 elsewhere.
- R10: The `irq` output equals the interrupt flag at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one byte per cycle |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| pin_i | input | 14 | Pin levels; bits 6:0 port 1, 13:7 port 2 |
| pin_o | output | 14 | Pin drive levels |
| pin_oe | output | 14 | Pin output enables, 1 = drive |
| ctl_out | input | 14 | Controller drive levels for controller mode |
| ctl_oe | input | 14 | Controller output enables for controller mode |
| latch_strobe | output | 1 | One-cycle pulse on a synchronized falling edge of port 1 bit 6 |
| irq | output | 1 | Sticky interrupt flag |

## Verification
A wrong mode bit or direction bit shows at `pin_oe` in the cycle after the write that set it. A stored data bit shows at `pin_o` in direct mode, or through the data register read-back, at once. A latch enable that failed to load shows as a driven bit 6 or as a missing strobe two edges after a falling edge. A sync stage off by one moves the strobe by a cycle, which a comparison made every clock catches immediately. A stuck or wrongly cleared interrupt flag shows on `irq` and on offset 6 in the next cycle.

// File: rtl/ppc_pkg.sv
`timescale 1ns/1ps
package ppc_pkg;

  localparam int BUS_W = 8;

  typedef enum logic [2:0] {
    RK_DATA,
    RK_DIR,
    RK_MODE,
    RK_LEN,
    RK_IRQ,
    RK_NONE
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [3:0]  idx;
  } reg_sel_t;

  // Offsets: data regs 0..np-1, direction regs np..2np-1, then mode,
  // latch enable and interrupt flag.
  function automatic reg_sel_t ppc_decode(input int unsigned a, input int unsigned np);
    reg_sel_t r;
    r.kind = RK_NONE;
    r.idx  = '0;
    if (a < np) begin
      r.kind = RK_DATA;
      r.idx  = 4'(a);
    end else if (a < 2 * np) begin
      r.kind = RK_DIR;
      r.idx  = 4'(a - np);
    end else if (a == 2 * np) begin
      r.kind = RK_MODE;
    end else if (a == 2 * np + 1) begin
      r.kind = RK_LEN;
    end else if (a == 2 * np + 2) begin
      r.kind = RK_IRQ;
    end
    return r;
  endfunction

endpackage

// File: rtl/ppc_regfile.sv
`timescale 1ns/1ps
module ppc_regfile
  import ppc_pkg::*;
#(
  parameter int PW = 7,
  parameter int NP = 2,
  parameter int AW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [BUS_W-1:0]     wdata,
  input  logic [NP*PW-1:0]     pin_i,
  input  logic [NP*PW-1:0]     force_in,
  input  logic                 irq_q,
  output logic [NP*PW-1:0]     data_q,
  output logic [NP*PW-1:0]     dir_q,
  output logic [NP-1:0]        mode_q,
  output logic                 len_q,
  output logic                 irq_clr,
  output logic [BUS_W-1:0]     rdata
);

  localparam int IW = (NP > 1) ? $clog2(NP) : 1;

  reg_sel_t dec;
  assign dec = ppc_decode(32'(addr), NP);

  logic [PW-1:0] data_r  [NP];
  logic [PW-1:0] dir_r   [NP];
  logic [PW-1:0] pin_r   [NP];
  logic [PW-1:0] force_r [NP];

  for (genvar p = 0; p < NP; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_r[p] <= '0;
      end else if (we && dec.kind == RK_DATA && dec.idx == 4'(p)) begin
        data_r[p] <= wdata[PW-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_r[p] <= '0;
      end else if (we && dec.kind == RK_DIR && dec.idx == 4'(p)) begin
        dir_r[p] <= wdata[PW-1:0];
      end
    end

    assign data_q[p*PW +: PW] = data_r[p];
    assign dir_q[p*PW +: PW]  = dir_r[p];
    assign pin_r[p]           = pin_i[p*PW +: PW];
    assign force_r[p]         = force_in[p*PW +: PW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (we && dec.kind == RK_MODE) begin
      mode_q <= wdata[NP-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= 1'b0;
    end else if (we && dec.kind == RK_LEN) begin
      len_q <= wdata[0];
    end
  end

  assign irq_clr = we && (dec.kind == RK_IRQ) && wdata[0];

  logic [IW-1:0] sel_idx;
  logic [PW-1:0] out_mask;
  logic [PW-1:0] rd_bits;

  assign sel_idx  = dec.idx[IW-1:0];
  assign out_mask = dir_r[sel_idx] & ~force_r[sel_idx];

  always_comb begin
    rd_bits = '0;
    rdata   = '0;
    unique case (dec.kind)
      RK_DATA: begin
        rd_bits = (data_r[sel_idx] & out_mask) | (pin_r[sel_idx] & ~out_mask);
        rdata   = BUS_W'(rd_bits);
      end
      RK_DIR: begin
        rdata = BUS_W'(dir_r[sel_idx]);
      end
      RK_IRQ: begin
        rdata = BUS_W'(irq_q);
      end
      default: begin
        rdata = '0;
      end
    endcase
  end

endmodule

// File: rtl/ppc_port_drive.sv
`timescale 1ns/1ps
module ppc_port_drive #(
  parameter int PW = 7
) (
  input  logic          direct,
  input  logic [PW-1:0] data,
  input  logic [PW-1:0] dir,
  input  logic [PW-1:0] ctl_out,
  input  logic [PW-1:0] ctl_oe,
  input  logic [PW-1:0] force_in,
  output logic [PW-1:0] pin_o,
  output logic [PW-1:0] pin_oe
);

  logic [PW-1:0] oe_raw;

  assign oe_raw = direct ? dir : ctl_oe;
  assign pin_o  = direct ? data : ctl_out;
  assign pin_oe = oe_raw & ~force_in;

endmodule

// File: rtl/ppc_latch_detect.sv
`timescale 1ns/1ps
module ppc_latch_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic enable,
  input  logic clr,
  output logic strobe,
  output logic flag
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign strobe = enable && last_q && !sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (strobe) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/pport_ctrl.sv
`timescale 1ns/1ps
module pport_ctrl
  import ppc_pkg::*;
#(
  parameter int PORT_W     = 7,
  parameter int NUM_PORTS  = 2,
  parameter int ADDR_W     = 3,
  parameter int LATCH_PORT = 0,
  parameter int LATCH_BIT  = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_we,
  input  logic [ADDR_W-1:0]           host_addr,
  input  logic [7:0]                  host_wdata,
  output logic [7:0]                  host_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_i,
  output logic [NUM_PORTS*PORT_W-1:0] pin_o,
  output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  input  logic [NUM_PORTS*PORT_W-1:0] ctl_out,
  input  logic [NUM_PORTS*PORT_W-1:0] ctl_oe,
  output logic                        latch_strobe,
  output logic                        irq
);

  localparam int TW        = NUM_PORTS * PORT_W;
  localparam int LATCH_IDX = LATCH_PORT * PORT_W + LATCH_BIT;

  logic [TW-1:0]        data_q;
  logic [TW-1:0]        dir_q;
  logic [NUM_PORTS-1:0] mode_q;
  logic                 len_q;
  logic                 irq_clr;
  logic                 irq_q;
  logic [TW-1:0]        force_vec;

  assign force_vec = TW'(len_q) << LATCH_IDX;

  ppc_regfile #(
    .PW (PORT_W),
    .NP (NUM_PORTS),
    .AW (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (host_we),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .pin_i    (pin_i),
    .force_in (force_vec),
    .irq_q    (irq_q),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .mode_q   (mode_q),
    .len_q    (len_q),
    .irq_clr  (irq_clr),
    .rdata    (host_rdata)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_drive
    ppc_port_drive #(
      .PW (PORT_W)
    ) u_drive (
      .direct   (mode_q[p]),
      .data     (data_q[p*PORT_W +: PORT_W]),
      .dir      (dir_q[p*PORT_W +: PORT_W]),
      .ctl_out  (ctl_out[p*PORT_W +: PORT_W]),
      .ctl_oe   (ctl_oe[p*PORT_W +: PORT_W]),
      .force_in (force_vec[p*PORT_W +: PORT_W]),
      .pin_o    (pin_o[p*PORT_W +: PORT_W]),
      .pin_oe   (pin_oe[p*PORT_W +: PORT_W])
    );
  end

  ppc_latch_detect #(
    .SYNC_STAGES (2)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (pin_i[LATCH_IDX]),
    .enable (len_q),
    .clr    (irq_clr),
    .strobe (latch_strobe),
    .flag   (irq_q)
  );

  assign irq = irq_q;

endmodule

// File: rtl/pport_ctrl_chk.sv
`timescale 1ns/1ps
module pport_ctrl_chk #(
  parameter int PORT_W     = 7,
  parameter int NUM_PORTS  = 2,
  parameter int ADDR_W     = 3,
  parameter int LATCH_PORT = 0,
  parameter int LATCH_BIT  = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        host_we,
  input logic [ADDR_W-1:0]           host_addr,
  input logic [7:0]                  host_wdata,
  input logic [7:0]                  host_rdata,
  input logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  input logic [NUM_PORTS*PORT_W-1:0] ctl_oe,
  input logic [NUM_PORTS*PORT_W-1:0] dir_q,
  input logic [NUM_PORTS-1:0]        mode_q,
  input logic                        len_q,
  input logic                        latch_strobe,
  input logic                        irq
);

  localparam int TW        = NUM_PORTS * PORT_W;
  localparam int LATCH_IDX = LATCH_PORT * PORT_W + LATCH_BIT;
  localparam logic [ADDR_W-1:0] IRQ_OFS  = ADDR_W'(2 * NUM_PORTS + 2);
  localparam logic [ADDR_W-1:0] DATA_END = ADDR_W'(NUM_PORTS);
  localparam logic [TW-1:0]     FMASK    = TW'(1) << LATCH_IDX;

  logic clr_wr;
  assign clr_wr = host_we && (host_addr == IRQ_OFS) && host_wdata[0];

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_strobe |=> !latch_strobe);

  p_strobe_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_strobe |-> len_q);

  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    latch_strobe |=> irq);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !latch_strobe) |=> !irq);

  p_latch_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    len_q |-> !pin_oe[LATCH_IDX]);

  p_data_bit7_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr < DATA_END) |-> !host_rdata[7]);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
    p_direct_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[p] |-> (((pin_oe ^ dir_q) & ~FMASK) >> (p * PORT_W)) % (1 << PORT_W) == 0);

    p_ctl_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[p] |-> (((pin_oe ^ ctl_oe) & ~FMASK) >> (p * PORT_W)) % (1 << PORT_W) == 0);
  end

endmodule

bind pport_ctrl pport_ctrl_chk #(
  .PORT_W     (PORT_W),
  .NUM_PORTS  (NUM_PORTS),
  .ADDR_W     (ADDR_W),
  .LATCH_PORT (LATCH_PORT),
  .LATCH_BIT  (LATCH_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_we      (host_we),
  .host_addr    (host_addr),
  .host_wdata   (host_wdata),
  .host_rdata   (host_rdata),
  .pin_oe       (pin_oe),
  .ctl_oe       (ctl_oe),
  .dir_q        (dir_q),
  .mode_q       (mode_q),
  .len_q        (len_q),
  .latch_strobe (latch_strobe),
  .irq          (irq)
);

// File: tb/pport_ctrl_tb.sv
`timescale 1ns/1ps
module pport_ctrl_tb;

  localparam int PW = 7;
  localparam int NP = 2;
  localparam int W  = PW * NP;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_we = 1'b0;
  logic [2:0]   host_addr = 3'd2;
  logic [7:0]   host_wdata = 8'h00;
  logic [7:0]   host_rdata;
  logic [W-1:0] pin_i = '1;
  logic [W-1:0] pin_o;
  logic [W-1:0] pin_oe;
  logic [W-1:0] ctl_out = '0;
  logic [W-1:0] ctl_oe = '0;
  logic         latch_strobe;
  logic         irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit p6 = 1'b1;

  always #2.5 clk = ~clk;

  pport_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we      (host_we),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .pin_i        (pin_i),
    .pin_o        (pin_o),
    .pin_oe       (pin_oe),
    .ctl_out      (ctl_out),
    .ctl_oe       (ctl_oe),
    .latch_strobe (latch_strobe),
    .irq          (irq)
  );

  // ---------------- reference model ----------------
  logic [PW-1:0] m_data [NP];
  logic [PW-1:0] m_dir  [NP];
  logic [NP-1:0] m_sel;
  bit            m_en;
  bit            m_irq;
  bit            hist [$];

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_data[p] = '0;
      m_dir[p]  = '0;
    end
    m_sel = '0;
    m_en  = 1'b0;
    m_irq = 1'b0;
    hist  = '{1'b1, 1'b1, 1'b1};
  endtask

  initial model_reset();

  function automatic bit exp_strobe();
    return m_en && hist[0] && !hist[1];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit stb;
      bit clr;
      stb = exp_strobe();
      clr = host_we && host_addr == 3'd6 && host_wdata[0];
      m_irq = stb || (m_irq && !clr);
      hist.push_back(pin_i[6]);
      void'(hist.pop_front());
      if (host_we) begin
        case (host_addr)
          3'd0, 3'd1: m_data[host_addr] = host_wdata[PW-1:0];
          3'd2, 3'd3: m_dir[host_addr - 3'd2] = host_wdata[PW-1:0];
          3'd4: m_sel = host_wdata[NP-1:0];
          3'd5: m_en = host_wdata[0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [PW-1:0] exp_oe(int p);
    logic [PW-1:0] v;
    v = m_sel[p] ? m_dir[p] : ctl_oe[p*PW +: PW];
    if (p == 0 && m_en) v[6] = 1'b0;
    return v;
  endfunction

  function automatic logic [PW-1:0] exp_o(int p);
    return m_sel[p] ? m_data[p] : ctl_out[p*PW +: PW];
  endfunction

  function automatic logic [7:0] exp_rdata();
    logic [PW-1:0] outm;
    int p;
    case (host_addr)
      3'd0, 3'd1: begin
        p = int'(host_addr);
        outm = m_dir[p];
        if (p == 0 && m_en) outm[6] = 1'b0;
        return {1'b0, (m_data[p] & outm) | (pin_i[p*PW +: PW] & ~outm)};
      end
      3'd2, 3'd3: return {1'b0, m_dir[int'(host_addr) - 2]};
      3'd6: return {7'b0, m_irq};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int p = 0; p < NP; p++) begin
        chk(m_sel[p] ? "R2 pin_oe direct" : "R3 pin_oe controller",
            32'(pin_oe[p*PW +: PW]), 32'(exp_oe(p)));
        chk(m_sel[p] ? "R2 pin_o direct" : "R3 pin_o controller",
            32'(pin_o[p*PW +: PW]), 32'(exp_o(p)));
      end
      if (m_en) chk("R7 latch bit forced input", 32'(pin_oe[6]), 32'(0));
      case (host_addr)
        3'd0, 3'd1: chk("R4 data read-back", 32'(host_rdata), 32'(exp_rdata()));
        3'd2, 3'd3: chk("R5 direction read-back", 32'(host_rdata), 32'(exp_rdata()));
        3'd5:       chk("R7 latch enable reads zero", 32'(host_rdata), 32'(exp_rdata()));
        3'd6:       chk("R9 flag read-back", 32'(host_rdata), 32'(exp_rdata()));
        default:    chk("R6 write-only or unmapped reads zero", 32'(host_rdata), 32'(exp_rdata()));
      endcase
      chk("R8 latch_strobe", 32'(latch_strobe), 32'(exp_strobe()));
      chk("R10 irq output", 32'(irq), 32'(m_irq));
    end
  end

  // ---------------- stimulus ----------------
  always @(posedge clk) begin
    #1;
    ctl_out = W'($urandom);
    ctl_oe  = W'($urandom);
    pin_i   = W'($urandom);
    pin_i[6] = p6;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      tick();
      host_addr = 3'($urandom_range(0, 7));
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    tick();
    host_we    = 1'b1;
    host_addr  = a;
    host_wdata = d;
    tick();
    host_we    = 1'b0;
    host_addr  = 3'($urandom_range(0, 7));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    host_addr = 3'd2;
    @(negedge clk);
    chk("R1 direction reads zero after reset", 32'(host_rdata), 32'(0));
    chk("R1 irq low after reset", 32'(irq), 32'(0));
    chk("R1 controller owns pin_oe after reset", 32'(pin_oe), 32'(ctl_oe));
    chk("R1 controller owns pin_o after reset", 32'(pin_o), 32'(ctl_out));
    idle(20);

    // controller mode: writes stored, pins untouched (R3)
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'hFF); wr(3'd3, 8'h0F);
    idle(20);

    // direct mode on both ports (R2, R4, R5)
    wr(3'd4, 8'h03); idle(20);
    wr(3'd2, 8'h55); wr(3'd0, 8'h7F); idle(10);
    wr(3'd3, 8'h2A); wr(3'd1, 8'h00); idle(10);
    wr(3'd4, 8'hFE); idle(15);   // port 2 direct only (R6)
    wr(3'd4, 8'h01); idle(15);   // port 1 direct only

    // latch enable with bit 6 configured as output (R7, R8, R9)
    wr(3'd2, 8'h7F);
    wr(3'd5, 8'h01);
    idle(6);
    for (int i = 0; i < 60; i++) begin
      tick();
      p6 = ~p6;
      idle($urandom_range(1, 6));
      if ($urandom_range(0, 3) == 0) wr(3'd6, 8'($urandom));
    end
    // clear write coincides with set: set wins (R9)
    p6 = 1'b1; idle(6);
    tick(); p6 = 1'b0;
    tick();
    wr(3'd6, 8'h01);
    idle(4);
    wr(3'd6, 8'h01);          // clear (R9)
    idle(4);
    wr(3'd5, 8'hFE);          // bit 0 clear: disables latch (R7)
    for (int i = 0; i < 20; i++) begin
      tick();
      p6 = ~p6;
      idle($urandom_range(2, 5));
    end
    wr(3'd4, 8'h00); idle(20);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

endmodule